// File: doc/BRIEF.md
# Two-Antenna Preamble Diversity Selector

This block chooses between two receive antennas while a packet preamble is arriving. It drives a one-hot switch control and watches a correlation-quality figure from the demodulator. On each antenna it first lets the external switch settle. It then listens for one symbol period and accepts the antenna as soon as a valid correlation sample rises strictly above a programmable threshold. If no sample passes before the listening period ends, it moves to the other antenna and repeats. It keeps alternating until an antenna passes. Once it has accepted an antenna it holds that choice until the receiver restarts the search.

All timing is counted in ticks of an external 1 µs strobe. The settle time (8 ticks) and the listening time (16 ticks) are parameters. One settle plus one listen on each antenna takes 48 µs, so a choice is made within the first four 16 µs preamble symbols. When the search mode is switched off, the antenna comes straight from a manual select input. A restart pulse, used for receiver re-arm, packet end or abort, drops the lock and begins a fresh search on the antenna in use at that moment.

Top module: `ant_div_ctrl`

## Requirements
- R1: `ant_sel` always has exactly one bit set. Bit 0 drives antenna 0 and bit 1 drives antenna 1, and `sel_idx` gives the index of that bit.
- R2: When search is enabled, or restarted, the block spends SETTLE_TICKS ticks (8) on the current antenna and then DWELL_TICKS ticks (16) listening. With a tick on every cycle, the first antenna change follows 25 rising edges after the edge that first samples the enable high.
- R3: Correlation samples that arrive while the switch is settling never cause a lock.
- R4: An antenna passes only when `corr_vld` is high and `corr` is strictly greater than `thr`. A sample equal to the threshold does not pass. The lock is shown on the edge after the passing sample.
- R5: While locked, with search enabled and no restart, `locked` stays high and the antenna does not change.
- R6: If no sample passes, the antenna changes at the end of every listening period. A full settle-plus-listen interval (24 ticks) separates successive changes, and the search returns to antenna 0 after two changes.
- R7: A restart pulse while search is enabled clears `locked` on the next edge. The antenna stays where it was, and the next change follows 24 ticks after the restart edge.
- R8: With search disabled, `sel_idx` takes the value of `manual_sel` on the next edge, `locked` is low, and correlation input has no effect.
- R9: The settle and listen timers advance only on cycles where `tick` is high. Without ticks, the antenna never changes while searching.
- R10: During reset, `ant_sel` is 2'b01, `sel_idx` is 0 and `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 1 µs timing strobe |
| search_en | input | 1 | 1: automatic diversity search, 0: manual antenna |
| manual_sel | input | 1 | Antenna index used when search is disabled |
| restart | input | 1 | Pulse: drop lock and restart the search |
| thr | input | CORR_W | Correlation pass threshold |
| corr | input | CORR_W | Correlation quality from the demodulator |
| corr_vld | input | 1 | Qualifies `corr` for one cycle |
| ant_sel | output | 2 | One-hot antenna switch drive |
| locked | output | 1 | An antenna has passed and is held |
| sel_idx | output | 1 | Index of the antenna currently driven |

## Verification
Some properties are checked on every cycle: the one-hot switch drive, the strict-greater condition behind every new lock, holding the lock, the effect of a restart, following the manual input when search is off, and freezing the antenna when no tick has arrived. Other behaviour can only be shown by the bench's scenarios, because it depends on how long the timers have been running: the exact 25- and 24-edge switch points, samples being ignored during the settle window, the return to antenna 0 after two empty listening periods, and a timer that resumes correctly after ticks stop for a long stretch.

// File: rtl/ant_div_pkg.sv
// Package: ant_div_pkg
// Shared types for the antenna diversity selector.
// Assumes exactly two antennas, so an antenna is addressed by one bit.
package ant_div_pkg;

    // Search phases of the selector
    typedef enum logic [1:0] {
        PH_MANUAL = 2'd0,   // search disabled, antenna from manual input
        PH_SETTLE = 2'd1,   // switch settling, samples ignored
        PH_LISTEN = 2'd2,   // evaluating correlation on current antenna
        PH_HOLD   = 2'd3    // antenna accepted and held
    } ph_t;

    localparam int unsigned NUM_ANT = 2;

endpackage

// File: rtl/ant_div_timer.sv
// Module: ant_div_timer
// Counts tick strobes for the current phase and flags the final tick.
// Assumes the controller clears it whenever a new phase begins
// other than by this timer's own expiry.
module ant_div_timer #(
    parameter int unsigned DWELL_TICKS  = 16,
    parameter int unsigned SETTLE_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic use_settle,
    output logic expire
);

    localparam int unsigned MAX_TICKS = (DWELL_TICKS > SETTLE_TICKS) ? DWELL_TICKS : SETTLE_TICKS;
    localparam int unsigned CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [CNT_W-1:0] DWELL_LAST  = CNT_W'(DWELL_TICKS - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    // Select the terminal count for the phase being timed
    always_comb begin
        last_val = use_settle ? SETTLE_LAST : DWELL_LAST;
    end

    // Expiry is the tick that completes the phase
    always_comb begin
        expire = tick && !clear && (cnt_q == last_val);
    end

    // Tick counter that wraps on expiry and clears on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ant_div_qual.sv
// Module: ant_div_qual
// Decides whether a correlation sample qualifies the current antenna.
// Assumes the window input is high only during the listening phase;
// equality with the threshold does not qualify.
module ant_div_qual #(
    parameter int unsigned CORR_W = 8
) (
    input  logic              window,
    input  logic              corr_vld,
    input  logic [CORR_W-1:0] corr,
    input  logic [CORR_W-1:0] thr,
    output logic              pass
);

    // Strictly-greater comparison gated by sample valid and window
    always_comb begin
        pass = window && corr_vld && (corr > thr);
    end

endmodule

// File: rtl/ant_div_fsm.sv
// Module: ant_div_fsm
// Phase sequencer and antenna register for the diversity selector.
// Assumes one settle then one listen per antenna, and that a qualifying
// sample during listening wins over a same-cycle timer expiry.
module ant_div_fsm
    import ant_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic search_en,
    input  logic manual_sel,
    input  logic restart,
    input  logic pass,
    input  logic expire,
    output ph_t  phase,
    output logic ant_idx,
    output logic timer_clear,
    output logic timer_settle,
    output logic window
);

    ph_t  ph_q, ph_d;
    logic idx_q, idx_d;

    // Next phase and antenna selection
    always_comb begin
        ph_d  = ph_q;
        idx_d = idx_q;
        if (!search_en) begin
            ph_d  = PH_MANUAL;
            idx_d = manual_sel;
        end else if (restart) begin
            ph_d = PH_SETTLE;
        end else begin
            case (ph_q)
                PH_MANUAL: ph_d = PH_SETTLE;
                PH_SETTLE: if (expire) ph_d = PH_LISTEN;
                PH_LISTEN: begin
                    if (pass) begin
                        ph_d = PH_HOLD;
                    end else if (expire) begin
                        ph_d  = PH_SETTLE;
                        idx_d = ~idx_q;
                    end
                end
                PH_HOLD:   ph_d = PH_HOLD;
                default:   ph_d = PH_MANUAL;
            endcase
        end
    end

    // Phase and antenna registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_MANUAL;
            idx_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            idx_q <= idx_d;
        end
    end

    // Timer control: hold it at zero outside timed phases and on restart
    always_comb begin
        timer_clear  = !search_en || restart || (ph_q == PH_MANUAL) || (ph_q == PH_HOLD);
        timer_settle = (ph_q == PH_SETTLE);
        window       = search_en && !restart && (ph_q == PH_LISTEN);
    end

    assign phase   = ph_q;
    assign ant_idx = idx_q;

endmodule

// File: rtl/ant_div_ctrl.sv
// Module: ant_div_ctrl
// Top of the two-antenna preamble diversity selector. Times a settle and
// a listen period per antenna from an external tick, locks onto the first
// antenna whose correlation exceeds the threshold, and otherwise follows
// a manual antenna choice. Assumes tick is a one-cycle strobe.
module ant_div_ctrl
    import ant_div_pkg::*;
#(
    parameter int unsigned CORR_W       = 8,
    parameter int unsigned DWELL_TICKS  = 16,
    parameter int unsigned SETTLE_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              search_en,
    input  logic              manual_sel,
    input  logic              restart,
    input  logic [CORR_W-1:0] thr,
    input  logic [CORR_W-1:0] corr,
    input  logic              corr_vld,
    output logic [1:0]        ant_sel,
    output logic              locked,
    output logic              sel_idx
);

    ph_t  phase;
    logic ant_idx;
    logic timer_clear;
    logic timer_settle;
    logic window;
    logic expire;
    logic pass;

    ant_div_timer #(
        .DWELL_TICKS (DWELL_TICKS),
        .SETTLE_TICKS(SETTLE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (timer_clear),
        .tick      (tick),
        .use_settle(timer_settle),
        .expire    (expire)
    );

    ant_div_qual #(
        .CORR_W(CORR_W)
    ) u_qual (
        .window  (window),
        .corr_vld(corr_vld),
        .corr    (corr),
        .thr     (thr),
        .pass    (pass)
    );

    ant_div_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .search_en   (search_en),
        .manual_sel  (manual_sel),
        .restart     (restart),
        .pass        (pass),
        .expire      (expire),
        .phase       (phase),
        .ant_idx     (ant_idx),
        .timer_clear (timer_clear),
        .timer_settle(timer_settle),
        .window      (window)
    );

    // One switch-drive bit per antenna
    for (genvar a = 0; a < NUM_ANT; a++) begin : g_drive
        assign ant_sel[a] = (ant_idx == 1'(a));
    end

    // Status outputs
    always_comb begin
        locked  = (phase == PH_HOLD);
        sel_idx = ant_idx;
    end

endmodule

// File: rtl/ant_div_chk.sv
// Module: ant_div_chk
// Port-level temporal checks for ant_div_ctrl, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module ant_div_chk #(
    parameter int unsigned CORR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              search_en,
    input logic              manual_sel,
    input logic              restart,
    input logic [CORR_W-1:0] thr,
    input logic [CORR_W-1:0] corr,
    input logic              corr_vld,
    input logic [1:0]        ant_sel,
    input logic              locked,
    input logic              sel_idx
);

    a_r1_onehot_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ant_sel) == 1) && ant_sel[sel_idx]);

    a_r4_strict_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(corr_vld) && ($past(corr) > $past(thr))));

    a_r5_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && search_en && !restart) |=> (locked && $stable(sel_idx)));

    a_r7_restart_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (search_en && restart) |=> (!locked && $stable(sel_idx)));

    a_r8_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !search_en |=> (!locked && (sel_idx == $past(manual_sel))));

    a_r9_tick_gates_switch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(search_en) && !$past(tick)) |-> $stable(sel_idx));

    bind ant_div_ctrl ant_div_chk #(.CORR_W(CORR_W)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .search_en (search_en),
        .manual_sel(manual_sel),
        .restart   (restart),
        .thr       (thr),
        .corr      (corr),
        .corr_vld  (corr_vld),
        .ant_sel   (ant_sel),
        .locked    (locked),
        .sel_idx   (sel_idx)
    );

endmodule

// File: tb/ant_div_ctrl_bench.sv
// Directed bench for ant_div_ctrl: one task per scenario.
module ant_div_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic          search_en = 1'b0;
    logic          manual_sel = 1'b0;
    logic          restart = 1'b0;
    logic [CW-1:0] thr = 8'd100;
    logic [CW-1:0] corr = 8'd0;
    logic          corr_vld = 1'b0;
    logic [1:0]    ant_sel;
    logic          locked;
    logic          sel_idx;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ant_div_ctrl #(.CORR_W(CW)) u_ant_div_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .search_en(search_en),
        .manual_sel(manual_sel), .restart(restart), .thr(thr), .corr(corr),
        .corr_vld(corr_vld), .ant_sel(ant_sel), .locked(locked), .sel_idx(sel_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one rising edge and settle just after it
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Count edges until sel_idx changes (limit 300)
    task automatic edges_to_switch(output int n);
        logic start;
        start = sel_idx;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            n++;
            if (sel_idx != start) break;
        end
    endtask

    task automatic t_reset();
        step(3);
        check(ant_sel == 2'b01, "R10 ant_sel", ant_sel, 1);
        check(sel_idx == 1'b0, "R10 sel_idx", sel_idx, 0);
        check(locked == 1'b0, "R10 locked", locked, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_manual();
        manual_sel = 1'b1;
        step();
        check(sel_idx == 1'b1, "R8 manual index", sel_idx, 1);
        check(ant_sel == 2'b10, "R1 drive for antenna 1", ant_sel, 2);
        corr = 8'd250; corr_vld = 1'b1;
        step(5);
        check(locked == 1'b0, "R8 correlation ignored when off", locked, 0);
        corr_vld = 1'b0;
        manual_sel = 1'b0;
        step();
        check(sel_idx == 1'b0, "R8 manual back to 0", sel_idx, 0);
    endtask

    task automatic t_timing();
        int n;
        search_en = 1'b1;
        edges_to_switch(n);
        check(n == 25, "R2 first switch edge count", n, 25);
        check(sel_idx == 1'b1, "R6 moved to antenna 1", sel_idx, 1);
        edges_to_switch(n);
        check(n == 24, "R6 second switch interval", n, 24);
        check(sel_idx == 1'b0, "R6 returned to antenna 0", sel_idx, 0);
        search_en = 1'b0;
        step();
    endtask

    task automatic t_settle_ignored();
        int n;
        bit seen = 1'b0;
        search_en = 1'b1;
        corr = 8'd250; corr_vld = 1'b1;
        for (int i = 0; i < 9; i++) begin
            step();
            if (locked) seen = 1'b1;
        end
        corr_vld = 1'b0;
        check(!seen, "R3 no lock from settle samples", seen, 0);
        edges_to_switch(n);
        check(n == 16 && !locked, "R3 search continued", n, 16);
        search_en = 1'b0;
        manual_sel = 1'b0;
        step();
    endtask

    task automatic t_threshold_lock_restart();
        int n;
        bit bad = 1'b0;
        search_en = 1'b1;
        step(9);
        corr = thr; corr_vld = 1'b1;
        edges_to_switch(n);
        check(n == 16 && !locked, "R4 equal value does not pass", n, 16);
        corr_vld = 1'b0;
        step(8);
        corr = thr + 8'd1; corr_vld = 1'b1;
        step();
        corr_vld = 1'b0;
        check(locked == 1'b1, "R4 strictly greater locks", locked, 1);
        check(sel_idx == 1'b1 && ant_sel == 2'b10, "R4 locked antenna 1", sel_idx, 1);
        for (int i = 0; i < 100; i++) begin
            step();
            if (!locked || sel_idx != 1'b1) bad = 1'b1;
        end
        check(!bad, "R5 lock held for 100 cycles", bad, 0);
        restart = 1'b1;
        step();
        restart = 1'b0;
        check(!locked && sel_idx == 1'b1, "R7 restart unlocks on same antenna", locked, 0);
        edges_to_switch(n);
        check(n == 24, "R7 switch after restart", n, 24);
        search_en = 1'b0;
        manual_sel = 1'b0;
        step();
        check(!locked && sel_idx == 1'b0, "R8 disable returns to manual", sel_idx, 0);
    endtask

    task automatic t_tick_gating();
        int n;
        tick = 1'b0;
        search_en = 1'b1;
        step(60);
        check(sel_idx == 1'b0, "R9 no switch without ticks", sel_idx, 0);
        tick = 1'b1;
        edges_to_switch(n);
        check(n == 24, "R9 timing resumes with ticks", n, 24);
        search_en = 1'b0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_manual();
        t_timing();
        t_settle_ignored();
        t_threshold_lock_restart();
        t_tick_gating();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule